// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a memory-mapped watchdog that measures time against a shared 64-bit free-running system counter supplied from outside. Instead of decrementing a private counter, it holds a 64-bit deadline and compares the incoming counter value against it on every clock. Software sets a timeout period and enables the watchdog. From then on it must refresh the watchdog before the deadline passes, either by writing to a dedicated refresh frame or by writing the control frame.

When a deadline passes, the block raises a first-stage signal meant to be wired to an interrupt, and it sets a new deadline one period later. If that second deadline also passes without a refresh, the block raises a second-stage signal meant to drive a warm system reset. A history bit records the second-stage event. Only a power-on reset clears it, so boot code can tell that the watchdog caused the last warm reset. The external bus is a simple single-cycle interface with separate selects for the two frames and a combinational read path.

Top module: `escal_wdog`

## Requirements
- R1: After power-on reset, both stage outputs are low and reads return 0 from the control word (0x000), the period (0x008) and both compare words.
- R2: In both frames, a read at offset 0xFCC returns the parameter ID_VALUE.
- R3: A write to control offset 0x000 refreshes the watchdog and loads enable from write-data bit 0. A refresh sets the deadline to the current counter value plus the period.
- R4: A write to control offset 0x008 stores a 32-bit period and refreshes the watchdog, using the newly written period for the deadline.
- R5: A write of any data to refresh-frame offset 0x000 drops a pending first-stage signal and sets the deadline to counter plus period.
- R6: When enabled, with the first stage low and the counter unsigned-greater-or-equal to the deadline, the first-stage output rises on the next clock and the deadline becomes counter plus period. A counter that has already gone past the deadline also triggers this.
- R7: When enabled, if the counter reaches the deadline while the first stage is high, the second-stage output rises on the next clock and the first stage stays high.
- R8: Writing 0 to control offset 0x000 clears enable. This drops both stage outputs, and no timeout is detected afterwards however far the counter advances.
- R9: The control word holds enable in bit 0, the first-stage state in bit 1 and the second-stage history in bit 2. The deadline reads as its low word at 0x010 and its high word at 0x014.
- R10: The second-stage history bit survives the warm reset input and is cleared only by power-on reset. Warm reset clears enable, the period, the deadline and both stage outputs.
- R11: The deadline sum wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| wrst_n | input | 1 | Warm reset, active low, asynchronous; clears all state except the history bit |
| sys_cnt | input | 64 | Shared free-running system counter value |
| sel_ctl | input | 1 | Selects the control frame |
| sel_kick | input | 1 | Selects the refresh frame |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | 12 | Byte offset inside the selected frame |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when nothing is read |
| stage1_o | output | 1 | First-stage timeout signal (interrupt) |
| stage2_o | output | 1 | Second-stage timeout signal (reset request) |

## Verification
The bench controls the system counter directly. It steps the counter to one below the deadline and then exactly onto it, which catches a comparator written as strictly greater. It also jumps far past a deadline, where a design that tests for equality would never fire. It holds the first stage pending to show that only a second expiry escalates. It refreshes with arbitrary data to show that a design decoding the write data would miss the kick. A warm reset after escalation exposes a history bit placed on the wrong reset, and a deadline computed near the top of the counter range checks that the sum wraps and is not saturated.

// File: rtl/escal_wdog_pkg.sv
package escal_wdog_pkg;
  localparam int unsigned CNT_W    = 64;
  localparam int unsigned PERIOD_W = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;

  localparam logic [ADDR_W-1:0] A_CTL    = 12'h000;
  localparam logic [ADDR_W-1:0] A_PERIOD = 12'h008;
  localparam logic [ADDR_W-1:0] A_DL_LO  = 12'h010;
  localparam logic [ADDR_W-1:0] A_DL_HI  = 12'h014;
  localparam logic [ADDR_W-1:0] A_KICK   = 12'h000;
  localparam logic [ADDR_W-1:0] A_IDENT  = 12'hFCC;

  typedef struct packed {
    logic hist2;
    logic st1;
    logic en;
  } ctl_word_t;

  // Deadline = now + period, modulo 2^CNT_W.
  function automatic logic [CNT_W-1:0] next_deadline(
    input logic [CNT_W-1:0]    now,
    input logic [PERIOD_W-1:0] period);
    return now + {{(CNT_W-PERIOD_W){1'b0}}, period};
  endfunction

  // Unsigned comparison, so a missed deadline is still seen.
  function automatic logic deadline_hit(
    input logic [CNT_W-1:0] now,
    input logic [CNT_W-1:0] deadline);
    return now >= deadline;
  endfunction
endpackage

// File: rtl/escal_wdog_bus.sv
module escal_wdog_bus
  import escal_wdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h0A5D_1001
) (
  input  logic                sel_ctl,
  input  logic                sel_kick,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  ctl_word_t           status,
  input  logic [PERIOD_W-1:0] period,
  input  logic [CNT_W-1:0]    deadline,
  output logic                wr_ctl,
  output logic                wr_period,
  output logic                wr_kick,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned PAD_W = DATA_W - $bits(ctl_word_t);

  assign wr_ctl    = wr_en && sel_ctl && (addr == A_CTL);
  assign wr_period = wr_en && sel_ctl && (addr == A_PERIOD);
  assign wr_kick   = wr_en && sel_kick && !sel_ctl && (addr == A_KICK);

  always_comb begin
    rdata = '0;
    if (rd_en && sel_ctl) begin
      case (addr)
        A_CTL:    rdata = {{PAD_W{1'b0}}, status};
        A_PERIOD: rdata = period;
        A_DL_LO:  rdata = deadline[DATA_W-1:0];
        A_DL_HI:  rdata = deadline[CNT_W-1:DATA_W];
        A_IDENT:  rdata = ID_VALUE;
        default:  rdata = '0;
      endcase
    end else if (rd_en && sel_kick) begin
      if (addr == A_IDENT) rdata = ID_VALUE;
    end
  end
endmodule

// File: rtl/escal_wdog_core.sv
module escal_wdog_core
  import escal_wdog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_n,
  input  logic [CNT_W-1:0]    sys_cnt,
  input  logic                wr_ctl,
  input  logic                wr_period,
  input  logic                wr_kick,
  input  logic [DATA_W-1:0]   wdata,
  output logic                en_q,
  output logic                st1_q,
  output logic                st2_q,
  output logic                hist2_q,
  output logic [PERIOD_W-1:0] period_q,
  output logic [CNT_W-1:0]    deadline_q,
  output logic                refresh_evt,
  output logic                expire_evt,
  output logic                escalate_evt
);
  logic [PERIOD_W-1:0] period_nxt;
  logic                en_nxt;
  logic                hit;

  assign refresh_evt  = wr_ctl || wr_period || wr_kick;
  assign period_nxt   = wr_period ? wdata[PERIOD_W-1:0] : period_q;
  assign en_nxt       = wr_ctl ? wdata[0] : en_q;
  assign hit          = deadline_hit(sys_cnt, deadline_q);
  assign expire_evt   = en_q && !refresh_evt && hit && !st1_q;
  assign escalate_evt = en_q && !refresh_evt && hit && st1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      period_q   <= '0;
      deadline_q <= '0;
      st1_q      <= 1'b0;
      st2_q      <= 1'b0;
    end else begin
      en_q     <= en_nxt;
      period_q <= period_nxt;
      if (refresh_evt) begin
        deadline_q <= next_deadline(sys_cnt, period_nxt);
        st1_q      <= 1'b0;
      end else if (expire_evt) begin
        deadline_q <= next_deadline(sys_cnt, period_q);
        st1_q      <= 1'b1;
      end
      if (escalate_evt) st2_q <= 1'b1;
      if (!en_nxt) begin
        st1_q <= 1'b0;
        st2_q <= 1'b0;
      end
    end
  end

  // History of a second-stage event; only power-on reset clears it.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            hist2_q <= 1'b0;
    else if (escalate_evt) hist2_q <= 1'b1;
  end
endmodule

// File: rtl/escal_wdog.sv
module escal_wdog
  import escal_wdog_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0A5D_1001
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        wrst_n,
  input  logic [63:0] sys_cnt,
  input  logic        sel_ctl,
  input  logic        sel_kick,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        stage1_o,
  output logic        stage2_o
);
  logic                rst_n;
  logic                wr_ctl, wr_period, wr_kick;
  logic                en_q, st1_q, st2_q, hist2_q;
  logic [PERIOD_W-1:0] period_q;
  logic [CNT_W-1:0]    deadline_q;
  logic                refresh_evt, expire_evt, escalate_evt;
  ctl_word_t           status;

  assign rst_n  = por_n && wrst_n;
  assign status = '{hist2: hist2_q, st1: st1_q, en: en_q};

  escal_wdog_bus #(.ID_VALUE(ID_VALUE)) u_bus (
    .sel_ctl   (sel_ctl),
    .sel_kick  (sel_kick),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .status    (status),
    .period    (period_q),
    .deadline  (deadline_q),
    .wr_ctl    (wr_ctl),
    .wr_period (wr_period),
    .wr_kick   (wr_kick),
    .rdata     (rdata)
  );

  escal_wdog_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_n        (por_n),
    .sys_cnt      (sys_cnt),
    .wr_ctl       (wr_ctl),
    .wr_period    (wr_period),
    .wr_kick      (wr_kick),
    .wdata        (wdata),
    .en_q         (en_q),
    .st1_q        (st1_q),
    .st2_q        (st2_q),
    .hist2_q      (hist2_q),
    .period_q     (period_q),
    .deadline_q   (deadline_q),
    .refresh_evt  (refresh_evt),
    .expire_evt   (expire_evt),
    .escalate_evt (escalate_evt)
  );

  assign stage1_o = st1_q;
  assign stage2_o = st2_q;
endmodule

// File: rtl/escal_wdog_chk.sv
module escal_wdog_chk (
  input logic        clk,
  input logic        por_n,
  input logic        wrst_n,
  input logic [63:0] sys_cnt,
  input logic        en_q,
  input logic        stage1_o,
  input logic        stage2_o,
  input logic        hist2_q,
  input logic        refresh_evt,
  input logic [31:0] period_q,
  input logic [63:0] deadline_q
);
  // R6: a deadline reached with stage one low raises stage one and re-arms
  assert_expire_R6: assert property (@(posedge clk) disable iff (!(por_n && wrst_n))
    (en_q && !stage1_o && !refresh_evt && (sys_cnt >= deadline_q))
      |=> (stage1_o && (deadline_q == $past(sys_cnt) + {32'h0, $past(period_q)})));

  // R7: stage two only ever rises on top of a raised stage one
  assert_stage_order_R7: assert property (@(posedge clk) disable iff (!(por_n && wrst_n))
    $rose(stage2_o) |-> stage1_o);

  // R7: an active stage two is always recorded in the history bit
  assert_hist_tracks_R7: assert property (@(posedge clk) disable iff (!(por_n && wrst_n))
    stage2_o |-> hist2_q);

  // R5: every refresh leaves stage one low
  assert_refresh_clears_R5: assert property (@(posedge clk) disable iff (!(por_n && wrst_n))
    refresh_evt |=> !stage1_o);

  // R8: disabled means both outputs low
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!(por_n && wrst_n))
    !en_q |-> (!stage1_o && !stage2_o));

  // R10: history bit never drops except under power-on reset
  assert_hist_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
    hist2_q |=> hist2_q);
endmodule

bind escal_wdog escal_wdog_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .wrst_n      (wrst_n),
  .sys_cnt     (sys_cnt),
  .en_q        (en_q),
  .stage1_o    (stage1_o),
  .stage2_o    (stage2_o),
  .hist2_q     (hist2_q),
  .refresh_evt (refresh_evt),
  .period_q    (period_q),
  .deadline_q  (deadline_q)
);

// File: tb/escal_wdog_test.sv
module escal_wdog_test;
  localparam logic [31:0] IDV = 32'h0A5D_1001;
  localparam bit CTL = 1'b1;
  localparam bit KICK = 1'b0;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wrst_n = 1'b1;
  logic [63:0] sys_cnt = '0;
  logic        sel_ctl = 1'b0, sel_kick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        stage1_o, stage2_o;

  int total = 0;
  int bad = 0;

  escal_wdog #(.ID_VALUE(IDV)) uut (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .sys_cnt(sys_cnt),
    .sel_ctl(sel_ctl), .sel_kick(sel_kick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .stage1_o(stage1_o), .stage2_o(stage2_o)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input bit frame, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_ctl = frame; sel_kick = !frame; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel_ctl = 1'b0; sel_kick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_rd(input bit frame, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel_ctl = frame; sel_kick = !frame; rd_en = 1'b1; addr = a;
    #1 d = rdata;
    sel_ctl = 1'b0; sel_kick = 1'b0; rd_en = 1'b0; addr = '0;
  endtask

  task automatic read_deadline(output logic [63:0] dl);
    logic [31:0] lo, hi;
    bus_rd(CTL, 12'h010, lo);
    bus_rd(CTL, 12'h014, hi);
    dl = {hi, lo};
  endtask

  task automatic t_reset;
    logic [31:0] v;
    logic [63:0] dl;
    check("R1 stage1 after por", stage1_o, 0);
    check("R1 stage2 after por", stage2_o, 0);
    bus_rd(CTL, 12'h000, v); check("R1 control word", v, 0);
    bus_rd(CTL, 12'h008, v); check("R1 period", v, 0);
    read_deadline(dl);       check("R1 deadline", dl, 0);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    bus_rd(CTL, 12'hFCC, v);  check("R2 id control frame", v, IDV);
    bus_rd(KICK, 12'hFCC, v); check("R2 id refresh frame", v, IDV);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    logic [63:0] dl;
    sys_cnt = 64'd1000;
    bus_wr(CTL, 12'h008, 32'd100);
    bus_wr(CTL, 12'h000, 32'd1);
    bus_rd(CTL, 12'h000, v); check("R3 R9 enable bit", v, 32'h1);
    bus_rd(CTL, 12'h008, v); check("R4 period stored", v, 32'd100);
    read_deadline(dl);       check("R3 deadline=cnt+period", dl, 64'd1100);
    check("R3 stage1 low", stage1_o, 0);
  endtask

  task automatic t_expire;
    logic [31:0] v;
    logic [63:0] dl;
    sys_cnt = 64'd1099;
    @(negedge clk); check("R6 one below deadline", stage1_o, 0);
    sys_cnt = 64'd1100;
    @(negedge clk); check("R6 stage1 at deadline", stage1_o, 1);
    check("R6 stage2 still low", stage2_o, 0);
    bus_rd(CTL, 12'h000, v); check("R9 control word stage1", v, 32'h3);
    read_deadline(dl);       check("R6 rearmed deadline", dl, 64'd1200);
  endtask

  task automatic t_kick;
    logic [63:0] dl;
    sys_cnt = 64'd1150;
    bus_wr(KICK, 12'h000, 32'hDEAD_BEEF);
    check("R5 kick clears stage1", stage1_o, 0);
    read_deadline(dl); check("R5 kick deadline", dl, 64'd1250);
  endtask

  task automatic t_escalate;
    logic [31:0] v;
    logic [63:0] dl;
    sys_cnt = 64'd5000;
    @(negedge clk); check("R6 missed deadline detected", stage1_o, 1);
    read_deadline(dl); check("R6 deadline after late expiry", dl, 64'd5100);
    sys_cnt = 64'd5099;
    @(negedge clk); check("R7 no escalation early", stage2_o, 0);
    sys_cnt = 64'd5100;
    @(negedge clk); check("R7 stage2 asserted", stage2_o, 1);
    check("R7 stage1 held", stage1_o, 1);
    bus_rd(CTL, 12'h000, v); check("R9 control word all set", v, 32'h7);
  endtask

  task automatic t_resets;
    logic [31:0] v;
    @(negedge clk); wrst_n = 1'b0;
    @(negedge clk); wrst_n = 1'b1;
    check("R10 warm reset stage1", stage1_o, 0);
    check("R10 warm reset stage2", stage2_o, 0);
    bus_rd(CTL, 12'h000, v); check("R10 history survives warm reset", v, 32'h4);
    bus_rd(CTL, 12'h008, v); check("R10 period cleared by warm reset", v, 0);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    bus_rd(CTL, 12'h000, v); check("R10 history cleared by por", v, 0);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    logic [63:0] dl;
    sys_cnt = 64'd0;
    bus_wr(CTL, 12'h008, 32'd50);
    bus_wr(CTL, 12'h000, 32'd1);
    read_deadline(dl); check("R3 enable deadline", dl, 64'd50);
    sys_cnt = 64'd20;
    bus_wr(CTL, 12'h008, 32'd40);
    read_deadline(dl); check("R4 period write refreshes with new value", dl, 64'd60);
    bus_wr(CTL, 12'h000, 32'd0);
    sys_cnt = 64'd1000;
    repeat (3) @(negedge clk);
    check("R8 stage1 quiet when disabled", stage1_o, 0);
    check("R8 stage2 quiet when disabled", stage2_o, 0);
    bus_rd(CTL, 12'h000, v); check("R8 control word disabled", v, 0);
  endtask

  task automatic t_wrap;
    logic [63:0] dl;
    bus_wr(CTL, 12'h008, 32'h100);
    sys_cnt = 64'hFFFF_FFFF_FFFF_FFC0;
    bus_wr(CTL, 12'h000, 32'd1);
    sys_cnt = 64'h10;
    read_deadline(dl); check("R11 wrapped deadline", dl, 64'hC0);
    check("R11 no expiry below wrapped deadline", stage1_o, 0);
    sys_cnt = 64'hC0;
    @(negedge clk); check("R11 expiry at wrapped deadline", stage1_o, 1);
    read_deadline(dl); check("R11 rearm after wrap", dl, 64'h1C0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    t_reset();
    t_ident();
    t_enable();
    t_expire();
    t_kick();
    t_escalate();
    t_resets();
    t_disable();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule